// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block caches recent virtual-to-physical page translations for a fixed 4 KB page size. A requester presents a virtual address and a write flag. In the same cycle, with no register between input and output, the block either reports a hit together with the translated physical address, or raises a miss. The miss flag appears before any result is consumed, so the requester can trap, have a handler install the translation, and retry the access. The low 12 address bits pass through unchanged. The upper bits form the virtual page number, and that number is compared against every entry at once, one comparator per entry.

A handler installs a translation through a fill port. The fill carries the virtual page number, the physical page number and the initial reference and dirty bits. If the page is already present, the fill overwrites that same entry. Otherwise it takes the lowest-numbered invalid entry, and when no entry is invalid it takes the least-recently-used one. Recency is tracked with a per-entry age. A hit or a fill makes the touched entry the youngest and ages only the entries that were younger than it. A lookup hit sets the entry's reference bit, and a write hit also sets its dirty bit. A clear input drops every reference bit at once. The entry count is a parameter, intended to lie between 16 and 512.

Top module: `tlb_fa`

## Requirements
- R1: On a hit, `lk_paddr` equals the entry's physical page number in bits [PA_W-1:12] and `lk_vaddr[11:0]` in bits [11:0], in the same cycle as the lookup.
- R2: `lk_miss` is high exactly when `lk_valid` is high and no valid entry holds the virtual page number `lk_vaddr[VA_W-1:12]`. `lk_hit` and `lk_miss` are never high together, and both are low when `lk_valid` is low.
- R3: After reset every entry is invalid, so every lookup misses until a fill occurs.
- R4: A fill of a page that is not present takes an invalid entry whenever one exists. As a result, N fills of distinct pages into an empty buffer all remain resident.
- R5: When all entries are valid, a fill of a page that is not present replaces the entry whose last hit or fill is oldest.
- R6: `lk_ref` and `lk_dirty` report the hit entry's status bits as they stood before the access. A lookup hit sets the entry's reference bit.
- R7: A hit with `lk_write` high sets the entry's dirty bit. A read hit leaves the dirty bit unchanged.
- R8: A `ref_clear` pulse clears the reference bit of every entry and leaves the dirty bits unchanged.
- R9: A fill whose virtual page number is already present overwrites that entry, and no other entry is evicted. A page is never held twice.
- R10: A fill writes `fill_ref` and `fill_dirty` as the entry's status. The next lookup of that page reports them.
- R11: When a fill and a lookup occur in the same cycle, the lookup reports the contents from before the fill and changes no state. The fill alone updates the entries and the ages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | Lookup is a write access |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent; retry after a fill |
| lk_paddr | output | PA_W | Translated physical address (zero on a miss) |
| lk_ref | output | 1 | Reference bit of the hit entry before the access |
| lk_dirty | output | 1 | Dirty bit of the hit entry before the access |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VA_W-12 | Virtual page number to install |
| fill_ppn | input | PA_W-12 | Physical page number to install |
| fill_ref | input | 1 | Initial reference bit |
| fill_dirty | input | 1 | Initial dirty bit |
| ref_clear | input | 1 | Clear all reference bits |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. Hit and miss are exclusive and are quiet when no lookup is requested. The page offset passes straight through on a hit. The match vector never has more than one bit set. A fill of a new page into a buffer that is not full grows the valid count by exactly one. A hit sets its entry's reference bit, and a write hit sets its dirty bit. A clear, when it is not overridden in the same cycle, leaves every reference bit zero. Other behaviours only show up over a sequence of operations, and the bench scenarios cover these. One is which entry least-recently-used replacement evicts after a chosen pattern of touches. Another is that a duplicate fill evicts nothing, which shows in a full count of resident pages. The last is that a lookup made in the same cycle as a fill leaves no trace on the status bits.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PAGE_OFS_W = 12;

  typedef struct packed {
    logic ref_b;
    logic dirty_b;
  } tlb_stat_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned N     = 16,
  parameter int unsigned VPN_W = 20
) (
  input  logic [N-1:0]     ent_valid,
  input  logic [VPN_W-1:0] ent_vpn [N],
  input  logic [VPN_W-1:0] key_lk,
  input  logic [VPN_W-1:0] key_fill,
  output logic [N-1:0]     match_lk,
  output logic [N-1:0]     match_fill
);
  // one comparator pair per entry
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_lk[g]   = ent_valid[g] && (ent_vpn[g] == key_lk);
    assign match_fill[g] = ent_valid[g] && (ent_vpn[g] == key_fill);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(N - 1);

  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] age_n [N];
  logic [IDX_W-1:0] touched_age;

  always_comb begin
    touched_age = age_q[touch_idx];
    for (int j = 0; j < N; j++) begin
      age_n[j] = age_q[j];
      if (touch_en) begin
        if (IDX_W'(j) == touch_idx) begin
          age_n[j] = '0;
        end else if (age_q[j] < touched_age) begin
          age_n[j] = age_q[j] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int j = 0; j < N; j++) begin
      if (age_q[j] == AGE_MAX) oldest_idx = IDX_W'(j);
    end
  end

  // ages start as a permutation and every touch keeps them one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) age_q[j] <= IDX_W'(j);
    end else if (touch_en) begin
      for (int j = 0; j < N; j++) age_q[j] <= age_n[j];
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     ent_valid,
  input  logic [N-1:0]     match_fill,
  input  logic [IDX_W-1:0] oldest_idx,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_dup;
  logic             any_free;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    for (int j = 0; j < N; j++) begin
      if (match_fill[j]) dup_idx = dup_idx | IDX_W'(j);
    end
    for (int j = N - 1; j >= 0; j--) begin
      if (!ent_valid[j]) free_idx = IDX_W'(j);
    end
    any_dup  = |match_fill;
    any_free = ~&ent_valid;
  end

  always_comb begin
    if (any_dup)       victim_idx = dup_idx;
    else if (any_free) victim_idx = free_idx;
    else               victim_idx = oldest_idx;
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int unsigned N    = 16,
  parameter int unsigned VA_W = 32,
  parameter int unsigned PA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic [VA_W-1:0]      lk_vaddr,
  input  logic                 lk_write,
  output logic                 lk_hit,
  output logic                 lk_miss,
  output logic [PA_W-1:0]      lk_paddr,
  output logic                 lk_ref,
  output logic                 lk_dirty,
  input  logic                 fill_valid,
  input  logic [VA_W-13:0]     fill_vpn,
  input  logic [PA_W-13:0]     fill_ppn,
  input  logic                 fill_ref,
  input  logic                 fill_dirty,
  input  logic                 ref_clear
);
  import tlb_pkg::*;

  localparam int unsigned OFS_W = PAGE_OFS_W;
  localparam int unsigned VPN_W = VA_W - OFS_W;
  localparam int unsigned PPN_W = PA_W - OFS_W;
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0]     valid_q, valid_n;
  logic [N-1:0]     ref_q, ref_n;
  logic [N-1:0]     dirty_q, dirty_n;
  logic [VPN_W-1:0] vpn_q [N];
  logic [PPN_W-1:0] ppn_q [N];

  logic [N-1:0]     match_lk, match_fill;
  logic [IDX_W-1:0] hit_idx, oldest_idx, victim_idx, touch_idx;
  logic             touch_en;
  logic             any_match;
  logic [PPN_W-1:0] hit_ppn;
  tlb_stat_t        hit_stat;

  tlb_cam #(.N(N), .VPN_W(VPN_W)) cam_i (
    .ent_valid (valid_q),
    .ent_vpn   (vpn_q),
    .key_lk    (lk_vaddr[VA_W-1:OFS_W]),
    .key_fill  (fill_vpn),
    .match_lk  (match_lk),
    .match_fill(match_fill)
  );

  tlb_victim #(.N(N), .IDX_W(IDX_W)) victim_i (
    .ent_valid (valid_q),
    .match_fill(match_fill),
    .oldest_idx(oldest_idx),
    .victim_idx(victim_idx)
  );

  tlb_lru #(.N(N), .IDX_W(IDX_W)) lru_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .oldest_idx(oldest_idx)
  );

  // result selection: match vector is one-hot, so OR-combine
  always_comb begin
    hit_idx  = '0;
    hit_ppn  = '0;
    hit_stat = '0;
    for (int j = 0; j < N; j++) begin
      if (match_lk[j]) begin
        hit_idx          = hit_idx | IDX_W'(j);
        hit_ppn          = hit_ppn | ppn_q[j];
        hit_stat.ref_b   = hit_stat.ref_b | ref_q[j];
        hit_stat.dirty_b = hit_stat.dirty_b | dirty_q[j];
      end
    end
    any_match = |match_lk;
  end

  assign lk_hit   = lk_valid && any_match;
  assign lk_miss  = lk_valid && !any_match;
  assign lk_paddr = lk_hit ? {hit_ppn, lk_vaddr[OFS_W-1:0]} : '0;
  assign lk_ref   = lk_hit && hit_stat.ref_b;
  assign lk_dirty = lk_hit && hit_stat.dirty_b;

  // recency update: a fill wins over a concurrent lookup
  always_comb begin
    touch_en  = fill_valid || lk_hit;
    touch_idx = fill_valid ? victim_idx : hit_idx;
  end

  // status next state
  always_comb begin
    valid_n = valid_q;
    ref_n   = ref_clear ? '0 : ref_q;
    dirty_n = dirty_q;
    if (fill_valid) begin
      valid_n[victim_idx] = 1'b1;
      ref_n[victim_idx]   = fill_ref;
      dirty_n[victim_idx] = fill_dirty;
    end else if (lk_hit) begin
      ref_n[hit_idx]   = 1'b1;
      dirty_n[hit_idx] = dirty_q[hit_idx] | lk_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_n;
      ref_q   <= ref_n;
      dirty_q <= dirty_n;
    end
  end

  // translation payload: no reset, written only by a fill
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic wr_en;
    assign wr_en = fill_valid && (victim_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        vpn_q[g] <= fill_vpn;
        ppn_q[g] <= fill_ppn;
      end
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int unsigned N     = 16,
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_write,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             fill_valid,
  input logic             ref_clear,
  input logic [N-1:0]     match_lk,
  input logic [N-1:0]     match_fill,
  input logic [N-1:0]     valid_q,
  input logic [N-1:0]     ref_q,
  input logic [N-1:0]     dirty_q,
  input logic [IDX_W-1:0] hit_idx
);
  a_r2_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[11:0] == lk_vaddr[11:0]));

  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match_lk) <= 1);

  a_r4_free_slot_used: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(|match_fill) && !(&valid_q))
      |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));

  a_r6_hit_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !fill_valid) |=> ref_q[$past(hit_idx)]);

  a_r7_write_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write && !fill_valid) |=> dirty_q[$past(hit_idx)]);

  a_r8_clear_all_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clear && !fill_valid && !lk_hit) |=> (ref_q == '0));
endmodule

bind tlb_fa tlb_fa_chk #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_vaddr  (lk_vaddr),
  .lk_write  (lk_write),
  .lk_hit    (lk_hit),
  .lk_miss   (lk_miss),
  .lk_paddr  (lk_paddr),
  .fill_valid(fill_valid),
  .ref_clear (ref_clear),
  .match_lk  (match_lk),
  .match_fill(match_fill),
  .valid_q   (valid_q),
  .ref_q     (ref_q),
  .dirty_q   (dirty_q),
  .hit_idx   (hit_idx)
);

// File: tb/tlb_fa_tb_top.sv
module tlb_fa_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_hit, lk_miss, lk_ref, lk_dirty;
  logic [31:0] lk_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_ref = 1'b0;
  logic        fill_dirty = 1'b0;
  logic        ref_clear = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic        r_hit, r_miss, r_ref, r_dirty;
  logic [31:0] r_pa;

  always #4 clk = ~clk;

  tlb_fa #(.N(N), .VA_W(32), .PA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_paddr(lk_paddr), .lk_ref(lk_ref), .lk_dirty(lk_dirty),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_ref(fill_ref), .fill_dirty(fill_dirty), .ref_clear(ref_clear)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] ofs, input bit wr);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, ofs}; lk_write = wr;
    #1;
    r_hit = lk_hit; r_miss = lk_miss; r_pa = lk_paddr;
    r_ref = lk_ref; r_dirty = lk_dirty;
    @(posedge clk); #1;
    lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input bit rf, input bit dt);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    fill_ref = rf; fill_dirty = dt;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(!lk_hit && !lk_miss, "R2 idle", {30'd0, lk_hit, lk_miss}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      look(20'h100 + 20'(i), 12'h0, 1'b0);
      check(r_miss && !r_hit, "R3 empty miss", {30'd0, r_hit, r_miss}, 32'd1);
    end
  endtask

  task automatic t_fill_all();
    for (int i = 0; i < N; i++) fill(20'h100 + 20'(i), 20'h500 + 20'(i), 1'b0, 1'b0);
    for (int i = 0; i < N; i++) begin
      look(20'h100 + 20'(i), 12'h3A4 + 12'(i), 1'b0);
      check(r_hit, "R4 all resident", {31'd0, r_hit}, 32'd1);
      check(r_pa == {20'h500 + 20'(i), 12'h3A4 + 12'(i)}, "R1 paddr", r_pa,
            {20'h500 + 20'(i), 12'h3A4 + 12'(i)});
    end
  endtask

  task automatic t_lru();
    look(20'h100, 12'h0, 1'b0);
    fill(20'h200, 20'h600, 1'b0, 1'b0);
    look(20'h101, 12'h0, 1'b0);
    check(r_miss, "R5 oldest evicted", {31'd0, r_miss}, 32'd1);
    look(20'h100, 12'h0, 1'b0);
    check(r_hit, "R5 touched kept", {31'd0, r_hit}, 32'd1);
    look(20'h200, 12'h0, 1'b0);
    check(r_hit && r_pa == 32'h0060_0000, "R5 new page", r_pa, 32'h0060_0000);
  endtask

  task automatic t_status();
    fill(20'h300, 20'h700, 1'b0, 1'b0);
    look(20'h300, 12'h0, 1'b0);
    check(!r_ref && !r_dirty, "R10 initial clear", {30'd0, r_ref, r_dirty}, 32'd0);
    look(20'h300, 12'h0, 1'b1);
    check(r_ref && !r_dirty, "R6 ref after hit", {30'd0, r_ref, r_dirty}, 32'd2);
    look(20'h300, 12'h0, 1'b0);
    check(r_dirty, "R7 dirty after write", {31'd0, r_dirty}, 32'd1);
    look(20'h300, 12'h0, 1'b0);
    check(r_dirty, "R7 read keeps dirty", {31'd0, r_dirty}, 32'd1);
    fill(20'h301, 20'h701, 1'b1, 1'b1);
    look(20'h301, 12'h0, 1'b0);
    check(r_ref && r_dirty, "R10 initial set", {30'd0, r_ref, r_dirty}, 32'd3);
  endtask

  task automatic t_clear();
    @(negedge clk); ref_clear = 1'b1;
    @(posedge clk); #1; ref_clear = 1'b0;
    look(20'h300, 12'h0, 1'b0);
    check(!r_ref && r_dirty, "R8 ref cleared dirty kept", {30'd0, r_ref, r_dirty}, 32'd1);
    look(20'h301, 12'h0, 1'b0);
    check(!r_ref, "R8 ref cleared", {31'd0, r_ref}, 32'd0);
  endtask

  task automatic t_dup();
    int hits = 0;
    fill(20'h300, 20'h777, 1'b0, 1'b0);
    look(20'h300, 12'h010, 1'b0);
    check(r_pa == 32'h0077_7010 && !r_dirty, "R9 overwrite", r_pa, 32'h0077_7010);
    look(20'h100, 12'h0, 1'b0); hits += int'(r_hit);
    for (int i = 4; i < N; i++) begin
      look(20'h100 + 20'(i), 12'h0, 1'b0); hits += int'(r_hit);
    end
    look(20'h200, 12'h0, 1'b0); hits += int'(r_hit);
    look(20'h300, 12'h0, 1'b0); hits += int'(r_hit);
    look(20'h301, 12'h0, 1'b0); hits += int'(r_hit);
    check(hits == N, "R9 nothing evicted", 32'(hits), 32'(N));
  endtask

  task automatic t_same_cycle();
    look(20'h200, 12'h0, 1'b0);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 32'h0020_0000; lk_write = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h400; fill_ppn = 20'h800;
    fill_ref = 1'b0; fill_dirty = 1'b0;
    #1;
    check(lk_hit && !lk_dirty, "R11 lookup sees old", {30'd0, lk_hit, lk_dirty}, 32'd2);
    @(posedge clk); #1;
    lk_valid = 1'b0; lk_write = 1'b0; fill_valid = 1'b0;
    look(20'h200, 12'h0, 1'b0);
    check(r_hit && !r_dirty, "R11 no state change", {30'd0, r_hit, r_dirty}, 32'd2);
    look(20'h400, 12'h0, 1'b0);
    check(r_hit && r_pa == 32'h0080_0000, "R11 fill applied", r_pa, 32'h0080_0000);
    look(20'h100, 12'h0, 1'b0);
    check(r_miss, "R5 lru victim", {31'd0, r_miss}, 32'd1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fill_all();
    t_lru();
    t_status();
    t_clear();
    t_dup();
    t_same_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule